// File: doc/BRIEF.md
# Primitive Assembly and X-Order Vertex Sorter

This block sits at the front of a rasterization setup pipeline. It takes in a single stream of words over a valid/ready handshake. A command word chooses how the vertex records that follow are grouped: single points, line segments, separate triangles, quadrilaterals, or a triangle strip. For every complete primitive it builds a record of up to four vertices. Triangle and quadrilateral records are reordered so that their X coordinates rise. The record is then handed to one of four parallel setup lanes, and each lane has its own valid/ready handshake.

Lanes are used in turn, round-robin. Each lane holds one primitive until its consumer takes it, so up to four primitives can be in flight downstream at once. A strip therefore spreads its triangles across all four lanes. The input stalls only when the lane whose turn has come is still occupied.

A command word that arrives before the current primitive has all its vertices discards the partial primitive and raises a one-cycle error pulse.

Top module: `primAsm`

## Requirements
- R1: Out of reset all `laneValid` bits and `errDrop` are low, the round-robin pointer is at lane 0, and `inReady` is high while `inValid` is low.
- R2: Command code 0 selects points. Every vertex gives a primitive of kind 0, with the vertex in slot 0 and slots 1 to 3 zero. A vertex word holds signed X in bits [15:0] and Y in bits [31:16]. Slot k of a lane sits at `laneVerts[lane][k]`.
- R3: Command code 1 selects lines. Each pair of vertices gives a primitive of kind 1, with the vertices in arrival order in slots 0 and 1 and no sorting.
- R4: Command code 2 selects separate triangles. Every three vertices give a primitive of kind 2, with slots 0 to 2 in ascending signed X and slot 3 zero.
- R5: Command code 3 selects quadrilaterals. Every four vertices give a primitive of kind 3, with slots 0 to 3 in ascending signed X.
- R6: Vertices with equal X keep their arrival order after sorting.
- R7: Command code 4 selects a strip. From the third vertex on, each vertex forms a kind-2 triangle with the two vertices before it, sorted as in R4.
- R8: Primitives of all kinds go to lanes 0, 1, 2, 3, 0, ... in order of completion, starting from lane 0 after reset.
- R9: While the next target lane holds a primitive that is not being taken, a vertex that would complete a primitive is not accepted (`inReady` low). A lane's valid, kind and vertices stay stable while it waits for `laneReady`.
- R10: If a command word is accepted while a primitive is partial, the partial vertices are discarded and `errDrop` is high for exactly the following cycle. A strip counts as partial only until its first triangle has formed. In every other case `errDrop` stays low.
- R11: Command code 7, and the unused codes 5 and 6, put the block into idle. Vertices accepted while idle, and vertices accepted before any command after reset, produce no primitive.
- R12: All four lanes can hold valid primitives at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high together with inValid |
| inIsCmd | input | 1 | High: word is a command; low: word is a vertex |
| inCmd | input | 3 | Command code (0 point, 1 line, 2 triangle, 3 quad, 4 strip, 7 idle) |
| inVtx | input | 32 | Vertex: Y in [31:16], signed X in [15:0] |
| laneValid | output | 4 | Per-lane primitive valid |
| laneReady | input | 4 | Per-lane consumer ready |
| laneKind | output | 4x2 | Per-lane primitive kind (0 point, 1 line, 2 triangle, 3 quad) |
| laneVerts | output | 4x4x32 | Per-lane vertex slots 0..3 |
| errDrop | output | 1 | One-cycle pulse: partial primitive discarded |

## Verification
Some rules are checked by assertions on every cycle. A lane that waits keeps its contents. No lane is loaded while it holds an untaken primitive. At most one lane is loaded per cycle. Every triangle and quad on a lane has non-decreasing X. `errDrop` only follows an accepted command. Idle vertices never cause a load. Other behaviour can only be shown by the bench's scenarios, which compare every lane output with a scoreboard model: which vertices are grouped together, tie order on equal X, the sliding window of a strip, the round-robin lane order, the stall when the target lane is full, and which commands count as interrupting a partial primitive.

// File: rtl/primAsmPkg.sv
package primAsmPkg;

  localparam logic [2:0] CMD_POINT = 3'd0;
  localparam logic [2:0] CMD_LINE  = 3'd1;
  localparam logic [2:0] CMD_TRI   = 3'd2;
  localparam logic [2:0] CMD_QUAD  = 3'd3;
  localparam logic [2:0] CMD_STRIP = 3'd4;
  localparam logic [2:0] CMD_IDLE  = 3'd7;

  localparam logic [1:0] KIND_POINT = 2'd0;
  localparam logic [1:0] KIND_LINE  = 2'd1;
  localparam logic [1:0] KIND_TRI   = 2'd2;
  localparam logic [1:0] KIND_QUAD  = 2'd3;

  localparam int MAX_VERTS = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic       vtxWrite;   // store incoming vertex at vtxSlot
    logic       stripShift; // slide the two-vertex strip window
    logic [1:0] vtxSlot;    // slot the incoming vertex occupies
    logic       emit;       // a primitive completes this cycle
    logic [1:0] emitKind;
    logic [2:0] emitCount;  // number of valid slots
    logic       doSort;     // order slots by X
  } strobeT;

endpackage

// File: rtl/primAsmCtrl.sv
module primAsmCtrl
  import primAsmPkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inIsCmd,
  input  logic [2:0]       inCmd,
  input  logic [LANES-1:0] laneBusy,
  output logic             inReady,
  output strobeT           strb,
  output logic [LANES-1:0] loadMask,
  output logic             errDrop
);

  logic [2:0]    modeR;
  logic [1:0]    cntR;
  logic [LW-1:0] rrPtr;

  logic isStrip, isList, active, completes, emitWanted, fire, partial;
  logic [2:0] need;

  always_comb begin
    isStrip = (modeR == CMD_STRIP);
    isList  = (modeR <= CMD_QUAD);
    active  = isStrip || isList;
    case (modeR)
      CMD_POINT: need = 3'd1;
      CMD_LINE:  need = 3'd2;
      CMD_TRI:   need = 3'd3;
      default:   need = 3'd4;
    endcase
    completes  = isStrip ? (cntR >= 2'd2) : ((3'(cntR) + 3'd1) == need);
    emitWanted = inValid && !inIsCmd && active && completes;
    inReady    = !(emitWanted && laneBusy[rrPtr]);
    fire       = inValid && inReady;
    if (isList)       partial = (cntR != 2'd0);
    else if (isStrip) partial = (cntR == 2'd1) || (cntR == 2'd2);
    else              partial = 1'b0;

    strb            = '0;
    strb.emit       = fire && emitWanted;
    strb.vtxWrite   = fire && !inIsCmd && active && !completes;
    strb.stripShift = fire && !inIsCmd && isStrip && completes;
    strb.vtxSlot    = (isStrip && cntR >= 2'd2) ? 2'd2 : cntR;
    strb.emitKind   = isStrip ? KIND_TRI : modeR[1:0];
    strb.emitCount  = isStrip ? 3'd3 : need;
    strb.doSort     = isStrip || (modeR == CMD_TRI) || (modeR == CMD_QUAD);

    loadMask = '0;
    if (strb.emit) loadMask[rrPtr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR   <= CMD_IDLE;
      cntR    <= 2'd0;
      rrPtr   <= '0;
      errDrop <= 1'b0;
    end else begin
      errDrop <= 1'b0;
      if (fire && inIsCmd) begin
        modeR   <= (inCmd <= CMD_STRIP) ? inCmd : CMD_IDLE;
        cntR    <= 2'd0;
        errDrop <= partial;
      end else if (fire && active) begin
        if (isStrip)        cntR <= (cntR == 2'd3) ? 2'd3 : cntR + 2'd1;
        else if (completes) cntR <= 2'd0;
        else                cntR <= cntR + 2'd1;
      end
      if (strb.emit)
        rrPtr <= (rrPtr == LW'(LANES - 1)) ? '0 : rrPtr + LW'(1);
    end
  end

  // R10: the drop pulse only ever follows an accepted command word
  a_r10_err_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    errDrop |-> $past(inValid && inReady && inIsCmd));

  // R11: vertices while idle are taken and leave no trace
  a_r11_idle_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inIsCmd && modeR == CMD_IDLE) |-> (inReady && !strb.emit && !strb.vtxWrite));

  // R9: a completing vertex is held off while its target lane is occupied
  a_r9_stall_busy: assert property (@(posedge clk) disable iff (!rstN)
    (emitWanted && laneBusy[rrPtr]) |-> !inReady);

endmodule

// File: rtl/primAsmData.sv
module primAsmData
  import primAsmPkg::*;
#(
  parameter int LANES = 4,
  parameter int XW    = 16,
  parameter int YW    = 16,
  localparam int VW   = XW + YW
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [VW-1:0]                        inVtx,
  input  strobeT                               strb,
  input  logic [LANES-1:0]                     loadMask,
  input  logic [LANES-1:0]                     laneReady,
  output logic [LANES-1:0]                     laneValid,
  output logic [LANES-1:0][1:0]                laneKind,
  output logic [LANES-1:0][MAX_VERTS-1:0][VW-1:0] laneVerts
);

  logic [MAX_VERTS-1:0][VW-1:0] vbR, cand, sorted, prim;
  logic [1:0] rank [MAX_VERTS];

  // candidate primitive: stored vertices plus the arriving one
  always_comb begin
    for (int i = 0; i < MAX_VERTS; i++) begin
      cand[i] = (2'(i) == strb.vtxSlot) ? inVtx : vbR[i];
      if (3'(i) >= strb.emitCount) cand[i] = '0;
    end
  end

  // stable rank sort on signed X: earlier slot wins on a tie
  always_comb begin
    for (int i = 0; i < MAX_VERTS; i++) begin
      rank[i] = 2'd0;
      for (int j = 0; j < MAX_VERTS; j++) begin
        if (j != i && 3'(j) < strb.emitCount) begin
          if (($signed(cand[j][XW-1:0]) < $signed(cand[i][XW-1:0])) ||
              ((cand[j][XW-1:0] == cand[i][XW-1:0]) && (j < i)))
            rank[i] = rank[i] + 2'd1;
        end
      end
    end
    sorted = '0;
    for (int i = 0; i < MAX_VERTS; i++)
      if (3'(i) < strb.emitCount) sorted[rank[i]] = cand[i];
    prim = strb.doSort ? sorted : cand;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbR <= '0;
    end else if (strb.stripShift) begin
      vbR[0] <= vbR[1];
      vbR[1] <= inVtx;
    end else if (strb.vtxWrite) begin
      vbR[strb.vtxSlot] <= inVtx;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneValid[l] <= 1'b0;
        laneKind[l]  <= '0;
        laneVerts[l] <= '0;
      end else if (loadMask[l]) begin
        laneValid[l] <= 1'b1;
        laneKind[l]  <= strb.emitKind;
        laneVerts[l] <= prim;
      end else if (laneReady[l]) begin
        laneValid[l] <= 1'b0;
      end
    end

    // R9: a waiting lane holds its contents
    a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rstN)
      (laneValid[l] && !laneReady[l]) |=> (laneValid[l] && $stable(laneVerts[l]) && $stable(laneKind[l])));

    // R9: never overwrite a primitive that has not been taken
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
      loadMask[l] |-> (!laneValid[l] || laneReady[l]));

    // R4: triangles leave in ascending X
    a_r4_tri_sorted: assert property (@(posedge clk) disable iff (!rstN)
      (laneValid[l] && laneKind[l] == KIND_TRI) |->
        ($signed(laneVerts[l][0][XW-1:0]) <= $signed(laneVerts[l][1][XW-1:0]) &&
         $signed(laneVerts[l][1][XW-1:0]) <= $signed(laneVerts[l][2][XW-1:0])));

    // R5: quadrilaterals leave in ascending X
    a_r5_quad_sorted: assert property (@(posedge clk) disable iff (!rstN)
      (laneValid[l] && laneKind[l] == KIND_QUAD) |->
        ($signed(laneVerts[l][0][XW-1:0]) <= $signed(laneVerts[l][1][XW-1:0]) &&
         $signed(laneVerts[l][1][XW-1:0]) <= $signed(laneVerts[l][2][XW-1:0]) &&
         $signed(laneVerts[l][2][XW-1:0]) <= $signed(laneVerts[l][3][XW-1:0])));
  end

  // R8: one lane at most receives a primitive per cycle
  a_r8_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadMask));

endmodule

// File: rtl/primAsm.sv
module primAsm
  import primAsmPkg::*;
#(
  parameter int LANES = 4,
  parameter int XW    = 16,
  parameter int YW    = 16,
  localparam int VW   = XW + YW
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    inValid,
  output logic                                    inReady,
  input  logic                                    inIsCmd,
  input  logic [2:0]                              inCmd,
  input  logic [VW-1:0]                           inVtx,
  output logic [LANES-1:0]                        laneValid,
  input  logic [LANES-1:0]                        laneReady,
  output logic [LANES-1:0][1:0]                   laneKind,
  output logic [LANES-1:0][MAX_VERTS-1:0][VW-1:0] laneVerts,
  output logic                                    errDrop
);

  strobeT           strb;
  logic [LANES-1:0] loadMask;
  logic [LANES-1:0] laneBusy;

  assign laneBusy = laneValid & ~laneReady;

  primAsmCtrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inIsCmd  (inIsCmd),
    .inCmd    (inCmd),
    .laneBusy (laneBusy),
    .inReady  (inReady),
    .strb     (strb),
    .loadMask (loadMask),
    .errDrop  (errDrop)
  );

  primAsmData #(.LANES(LANES), .XW(XW), .YW(YW)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .inVtx     (inVtx),
    .strb      (strb),
    .loadMask  (loadMask),
    .laneReady (laneReady),
    .laneValid (laneValid),
    .laneKind  (laneKind),
    .laneVerts (laneVerts)
  );

endmodule

// File: tb/primAsm_bench.sv
`timescale 1ns/1ps
module primAsm_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic inIsCmd = 1'b0;
  logic [2:0] inCmd = 3'd0;
  logic [31:0] inVtx = '0;
  logic [3:0] laneValid;
  logic [3:0] laneReady = '0;
  logic [3:0][1:0] laneKind;
  logic [3:0][3:0][31:0] laneVerts;
  logic errDrop;

  always #2 clk = ~clk;

  primAsm u_primAsm (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inIsCmd(inIsCmd), .inCmd(inCmd), .inVtx(inVtx),
    .laneValid(laneValid), .laneReady(laneReady), .laneKind(laneKind),
    .laneVerts(laneVerts), .errDrop(errDrop)
  );

  typedef struct { logic [129:0] d; int rq; } expT;
  expT expQ [4][$];

  int checks = 0;
  int failures = 0;
  int readyMode = 0;
  bit finished = 0;

  int mMode = 7;
  int mCnt = 0;
  int mPtr = 0;
  logic [31:0] mBuf [4];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [129:0] act, input logic [129:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk(input int x, input int y);
    return {16'(y), 16'(x)};
  endfunction

  // scoreboard push: stable insertion sort on signed X when asked
  function automatic void modelPush(input logic [1:0] kind, input int n,
                                    input logic [31:0] vin [4], input bit doSort, input int rq);
    logic [31:0] a [4];
    logic [31:0] key;
    expT e;
    for (int i = 0; i < 4; i++) a[i] = (i < n) ? vin[i] : 32'd0;
    if (doSort) begin
      for (int i = 1; i < n; i++) begin
        int j;
        key = a[i];
        j = i - 1;
        while (j >= 0 && $signed(a[j][15:0]) > $signed(key[15:0])) begin
          a[j+1] = a[j];
          j--;
        end
        a[j+1] = key;
      end
    end
    e.d = {kind, a[3], a[2], a[1], a[0]};
    e.rq = rq;
    expQ[mPtr].push_back(e);
    mPtr = (mPtr + 1) % 4;
  endfunction

  function automatic void modelVtx(input logic [31:0] v, input int rq);
    logic [31:0] t [4];
    int need;
    if (mMode <= 3) begin
      need = mMode + 1;
      mBuf[mCnt] = v;
      mCnt++;
      if (mCnt == need) begin
        modelPush(2'(mMode), need, mBuf, mMode >= 2, rq);
        mCnt = 0;
      end
    end else if (mMode == 4) begin
      if (mCnt >= 2) begin
        t[0] = mBuf[0]; t[1] = mBuf[1]; t[2] = v; t[3] = 32'd0;
        modelPush(2'd2, 3, t, 1'b1, rq);
        mBuf[0] = mBuf[1];
        mBuf[1] = v;
        mCnt = 3;
      end else begin
        mBuf[mCnt] = v;
        mCnt++;
      end
    end
  endfunction

  function automatic bit modelCmd(input int c);
    bit part;
    part = (mMode <= 3 && mCnt != 0) || (mMode == 4 && (mCnt == 1 || mCnt == 2));
    mMode = (c <= 4) ? c : 7;
    mCnt = 0;
    return part;
  endfunction

  task automatic waitAccept;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic sendVtx(input int x, input int y, input int rq);
    modelVtx(mk(x, y), rq);
    @(negedge clk);
    inValid = 1'b1; inIsCmd = 1'b0; inVtx = mk(x, y);
    waitAccept();
  endtask

  // R10: drop pulse expected exactly when the model says a primitive was partial
  task automatic sendCmd(input int c);
    bit expErr;
    expErr = modelCmd(c);
    @(negedge clk);
    inValid = 1'b1; inIsCmd = 1'b1; inCmd = 3'(c);
    waitAccept();
    @(negedge clk);
    inValid = 1'b0;
    #1;
    chk(errDrop == expErr, "R10", "errDrop after command", 130'(errDrop), 130'(expErr));
    @(negedge clk);
    #1;
    chk(errDrop == 1'b0, "R10", "errDrop one cycle only", 130'(errDrop), 130'd0);
  endtask

  task automatic idleIn;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while ((expQ[0].size() + expQ[1].size() + expQ[2].size() + expQ[3].size()) != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    case (readyMode)
      0: laneReady = 4'h0;
      1: laneReady = 4'hF;
      default: laneReady = 4'($urandom);
    endcase
  end

  // monitor: compare every taken lane output with the lane's queue (R8 lane order)
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      for (int l = 0; l < 4; l++) begin
        if (laneValid[l] && laneReady[l]) begin
          if (expQ[l].size() == 0) begin
            chk(1'b0, "R11", $sformatf("unexpected primitive on lane %0d", l),
                {laneKind[l], laneVerts[l]}, 130'd0);
          end else begin
            expT e;
            e = expQ[l].pop_front();
            chk({laneKind[l], laneVerts[l]} == e.d, $sformatf("R%0d/R8", e.rq),
                $sformatf("primitive on lane %0d", l), {laneKind[l], laneVerts[l]}, e.d);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not complete", 130'd0, 130'd1);
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk(laneValid == 4'h0, "R1", "laneValid in reset", 130'(laneValid), 130'd0);
    chk(errDrop == 1'b0, "R1", "errDrop in reset", 130'(errDrop), 130'd0);
    chk(inReady == 1'b1, "R1", "inReady in reset", 130'(inReady), 130'd1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(laneValid == 4'h0, "R1", "laneValid after reset", 130'(laneValid), 130'd0);

    // R11: vertices before any command are ignored
    readyMode = 1;
    sendVtx(1, 1, 11);
    sendVtx(2, 2, 11);
    idleIn();
    repeat (4) @(negedge clk);
    #1;
    chk(laneValid == 4'h0, "R11", "no output before first command", 130'(laneValid), 130'd0);

    readyMode = 2;
    // R2: points
    sendCmd(0);
    sendVtx(-5, 10, 2);
    sendVtx(7, 11, 2);
    sendVtx(0, 12, 2);
    // R3: lines, no sort
    sendCmd(1);
    sendVtx(9, 1, 3);
    sendVtx(-9, 2, 3);
    sendVtx(3, 3, 3);
    sendVtx(4, 4, 3);
    // R4: triangles with signed X
    sendCmd(2);
    sendVtx(5, 1, 4);
    sendVtx(-3, 2, 4);
    sendVtx(2, 3, 4);
    sendVtx(-100, 4, 4);
    sendVtx(-200, 5, 4);
    sendVtx(300, 6, 4);
    // R6: ties keep arrival order
    sendVtx(4, 7, 6);
    sendVtx(4, 8, 6);
    sendVtx(1, 9, 6);
    // R5: quads
    sendCmd(3);
    sendVtx(10, 1, 5);
    sendVtx(-20, 2, 5);
    sendVtx(0, 3, 5);
    sendVtx(7, 4, 5);
    sendVtx(6, 5, 6);
    sendVtx(6, 6, 6);
    sendVtx(-1, 7, 6);
    sendVtx(6, 8, 6);
    // R7: strip of five vertices gives three triangles
    sendCmd(4);
    sendVtx(8, 1, 7);
    sendVtx(2, 2, 7);
    sendVtx(5, 3, 7);
    sendVtx(-4, 4, 7);
    sendVtx(9, 5, 7);
    // completed strip then idle: no error
    sendCmd(7);
    // R10: partial triangle interrupted by a line command
    sendCmd(2);
    sendVtx(1, 1, 10);
    sendVtx(2, 2, 10);
    sendCmd(1);
    sendVtx(20, 1, 10);
    sendVtx(-20, 2, 10);
    // R10: partial strip ended by idle
    sendCmd(4);
    sendVtx(3, 3, 10);
    sendVtx(4, 4, 10);
    sendCmd(7);
    // R10: partial quad interrupted by unused code 5
    sendCmd(3);
    sendVtx(1, 1, 10);
    sendCmd(5);
    idleIn();
    drain();

    // R11: vertices after idle code produce nothing
    readyMode = 1;
    sendCmd(7);
    sendVtx(5, 5, 11);
    sendVtx(6, 6, 11);
    sendVtx(7, 7, 11);
    idleIn();
    repeat (4) @(negedge clk);
    #1;
    chk(laneValid == 4'h0, "R11", "no output while idle", 130'(laneValid), 130'd0);

    // R12 and R9: fill every lane, then stall
    readyMode = 0;
    sendCmd(0);
    sendVtx(11, 0, 12);
    sendVtx(12, 0, 12);
    sendVtx(13, 0, 12);
    sendVtx(14, 0, 12);
    idleIn();
    #1;
    chk(laneValid == 4'hF, "R12", "all four lanes valid together", 130'(laneValid), 130'hF);
    modelVtx(mk(15, 0), 9);
    @(negedge clk);
    inValid = 1'b1; inIsCmd = 1'b0; inVtx = mk(15, 0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(inReady == 1'b0, "R9", "completing vertex stalled on busy lane", 130'(inReady), 130'd0);
      chk(laneValid == 4'hF, "R9", "lanes hold while not taken", 130'(laneValid), 130'hF);
      @(negedge clk);
    end
    readyMode = 1;
    waitAccept();
    idleIn();
    drain();

    chk((expQ[0].size() + expQ[1].size() + expQ[2].size() + expQ[3].size()) == 0,
        "R8", "all expected primitives delivered",
        130'(expQ[0].size() + expQ[1].size() + expQ[2].size() + expQ[3].size()), 130'd0);
    finish();
  end

endmodule